// File: doc/BRIEF.md
# Display Transmitter Register Stub on I2C

This block is a two-wire bus target that presents the smallest register face of a digital video transmitter. Host software probing the bus finds a device at address 0x39, reads back a fixed chip identifier and a status byte reporting an attached sink, and then uses a request/grant handshake in a system control register. That handshake puts the device into monitor-channel mode, after which the host reads the monitor's capability data from a separate memory on the same bus. Every other configuration write is acknowledged and discarded.

The design samples SCL and SDA through a configurable synchroniser running on a fast system clock, and detects START, STOP and the clock edges in that domain. A bit engine matches the address, generates acknowledges, shifts write data in and read data out MSB first. A small register bank holds an 8-bit auto-incrementing pointer, a pending flag for the pointer byte, the request flag and the channel-mode flag. SDA is driven open-drain: the block only ever pulls the line low. `link_mode_o` reports channel mode to the rest of the chip.

Top module: `disp_xmtr_i2c_stub`

## Requirements
- R1: The target acknowledges a transfer addressed to 7-bit address 0x39 (address byte 0x72 to write, 0x73 to read) by pulling SDA low during the ninth clock, and leaves SDA released for any other address.
- R2: In a write transfer the first data byte after the address byte loads the register pointer and writes no register.
- R3: Every further byte in that write transfer is written to the register the pointer selects, after which the pointer advances by one.
- R4: Every byte read returns the register the pointer selects, after which the pointer advances by one, wrapping from 0xFF to 0x00.
- R5: Register 0x1B reads 0xB0 (chip identifier) at all times.
- R6: Register 0x3D reads 0x04 (sink present, no plug event pending) at all times.
- R7: Writing register 0x1A with bit 2 set sets the request flag; if bit 1 is set in the same byte, channel mode is entered (`link_mode_o` high); bit 2 set with bit 1 clear leaves channel mode unchanged.
- R8: Writing register 0x1A with bit 2 clear clears both the request flag and channel mode.
- R9: Register 0x1A reads 0x06 while the request flag is set and 0x00 otherwise.
- R10: Every data byte written to the target is acknowledged; all registers other than 0x1A ignore writes, and all registers other than 0x1A, 0x1B and 0x3D read 0x00.
- R11: Reset (rst_n low at a clock edge) sets the pointer to 0x00 and clears the request flag, channel mode and the pointer-pending flag; after reset SDA is released.
- R12: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high; a repeated START restarts address matching, and STOP releases SDA.
- R13: Read data is driven MSB first; after the master answers a read byte with NACK the target releases SDA and drives nothing until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High to pull the data line low |
| link_mode_o | output | 1 | High while monitor-channel mode is active |

## Verification
The bench builds the block with its default parameters: address 0x39, identifier 0xB0, plug status 0x04 and a two-stage synchroniser, with each bus phase six system clocks long so that the synchroniser delay sits well inside a phase. With those values a table of write-then-read vectors reaches every handshake combination on register 0x1A, including request without grant and grant without request. Directed transfers cover the pointer byte, multi-byte auto-increment and a 257-byte read that shows the pointer wrapping back to the identifier. They also cover a wrong address followed by a repeated START and a reset taken while channel mode is active.

// File: rtl/disp_stub_pkg.sv
// Package: shared constants and types for the display transmitter stub.
// Assumes a byte-wide register space addressed by an 8-bit pointer.
package disp_stub_pkg;

    localparam int BYTE_W = 8;

    // Register offsets the host software decodes.
    localparam logic [BYTE_W-1:0] REG_SYSCTL  = 8'h1A;
    localparam logic [BYTE_W-1:0] REG_CHIPID  = 8'h1B;
    localparam logic [BYTE_W-1:0] REG_INTSTAT = 8'h3D;

    // Bit positions inside the system control register.
    localparam int SYSCTL_REQ_BIT = 2;
    localparam int SYSCTL_GNT_BIT = 1;

    // Bit engine states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BIT,
        ST_WR_ACK,
        ST_RD_BIT,
        ST_RD_ACK
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clk domain through STAGES flops and derives
// START, STOP and SCL rising/falling strobes (one clk each).
// Assumes STAGES >= 2 and bus phases longer than STAGES+2 clk cycles.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    // Synchroniser chains plus one history flop, idle-high at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    // Bus condition decode from current and previous synchronised levels.
    always_comb begin
        sda_o      = sda_now;
        start_o    = scl_now && scl_prev && sda_prev && !sda_now;
        stop_o     = scl_now && scl_prev && !sda_prev && sda_now;
        scl_rise_o = scl_now && !scl_prev;
        scl_fall_o = !scl_now && scl_prev;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
// Module: i2c_tgt_engine
// Bit-level target: matches the 7-bit address, acknowledges, shifts write
// bytes in and read bytes out MSB first, and signals the register bank.
// Assumes strobes from i2c_line_sync; SDA changes are made on SCL falls.
module i2c_tgt_engine
    import disp_stub_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              start_s,
    input  logic              stop_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_open,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              rd_adv,
    output tgt_state_e        state_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    tgt_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shift_q;
    logic              rw_q;
    logic              oe_q;
    logic              mack_q;
    logic              open_q;
    logic              valid_q;
    logic              adv_q;

    assign sda_oe   = oe_q;
    assign wr_open  = open_q;
    assign wr_valid = valid_q;
    assign wr_byte  = shift_q;
    assign rd_adv   = adv_q;
    assign state_o  = state_q;

    // Bus protocol sequencing, one decision per detected bus event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            rw_q    <= 1'b0;
            oe_q    <= 1'b0;
            mack_q  <= 1'b0;
            open_q  <= 1'b0;
            valid_q <= 1'b0;
            adv_q   <= 1'b0;
        end else begin
            open_q  <= 1'b0;
            valid_q <= 1'b0;
            adv_q   <= 1'b0;
            if (start_s) begin
                state_q <= ST_ADDR;
                cnt_q   <= '0;
                oe_q    <= 1'b0;
            end else if (stop_s) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shift_q <= {shift_q[BYTE_W-2:0], sda_s};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == CNT_FULL) begin
                            if (shift_q[BYTE_W-1:1] == DEV_ADDR) begin
                                oe_q    <= 1'b1;
                                rw_q    <= shift_q[0];
                                open_q  <= !shift_q[0];
                                state_q <= ST_ADDR_ACK;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (rw_q) begin
                                shift_q <= rd_data;
                                oe_q    <= !rd_data[BYTE_W-1];
                                adv_q   <= 1'b1;
                                state_q <= ST_RD_BIT;
                            end else begin
                                oe_q    <= 1'b0;
                                state_q <= ST_WR_BIT;
                            end
                        end
                    end
                    ST_WR_BIT: begin
                        if (scl_rise) begin
                            shift_q <= {shift_q[BYTE_W-2:0], sda_s};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == CNT_FULL) begin
                            oe_q    <= 1'b1;
                            valid_q <= 1'b1;
                            state_q <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            oe_q    <= 1'b0;
                            cnt_q   <= '0;
                            state_q <= ST_WR_BIT;
                        end
                    end
                    ST_RD_BIT: begin
                        if (scl_fall) begin
                            if (cnt_q == CNT_LAST) begin
                                oe_q    <= 1'b0;
                                state_q <= ST_RD_ACK;
                            end else begin
                                shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
                                oe_q    <= !shift_q[BYTE_W-2];
                                cnt_q   <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= !sda_s;
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                shift_q <= rd_data;
                                oe_q    <= !rd_data[BYTE_W-1];
                                adv_q   <= 1'b1;
                                cnt_q   <= '0;
                                state_q <= ST_RD_BIT;
                            end else begin
                                oe_q    <= 1'b0;
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        oe_q <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/disp_reg_bank.sv
// Module: disp_reg_bank
// Pointer, pointer-pending flag and channel handshake state; returns the
// read value for the pointed register combinationally.
// Assumes wr_open, wr_valid and rd_adv are single-cycle and never coincide.
module disp_reg_bank
    import disp_stub_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ID_VALUE   = 8'hB0,
    parameter logic [BYTE_W-1:0] PLUG_VALUE = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_open,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_adv,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] ptr_o,
    output logic              req_o,
    output logic              mode_o
);

    localparam logic [BYTE_W-1:0] SYSCTL_ACK =
        BYTE_W'((1 << SYSCTL_REQ_BIT) | (1 << SYSCTL_GNT_BIT));

    logic [BYTE_W-1:0] ptr_q;
    logic              pend_q;
    logic              req_q;
    logic              mode_q;

    assign ptr_o  = ptr_q;
    assign req_o  = req_q;
    assign mode_o = mode_q;

    // Pointer load/advance and system control handshake updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            pend_q <= 1'b0;
            req_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            if (wr_open) begin
                pend_q <= 1'b1;
            end
            if (wr_valid) begin
                if (pend_q) begin
                    ptr_q  <= wr_byte;
                    pend_q <= 1'b0;
                end else begin
                    if (ptr_q == REG_SYSCTL) begin
                        if (wr_byte[SYSCTL_REQ_BIT]) begin
                            req_q <= 1'b1;
                            if (wr_byte[SYSCTL_GNT_BIT]) begin
                                mode_q <= 1'b1;
                            end
                        end else begin
                            req_q  <= 1'b0;
                            mode_q <= 1'b0;
                        end
                    end
                    ptr_q <= ptr_q + 1'b1;
                end
            end else if (rd_adv) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // Read value of the register the pointer selects.
    always_comb begin
        case (ptr_q)
            REG_SYSCTL:  rd_data = req_q ? SYSCTL_ACK : '0;
            REG_CHIPID:  rd_data = ID_VALUE;
            REG_INTSTAT: rd_data = PLUG_VALUE;
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/disp_xmtr_i2c_stub.sv
// Module: disp_xmtr_i2c_stub (top)
// Two-wire bus target exposing identity, plug status and the monitor
// channel request/grant handshake of a video transmitter.
// Assumes clk is several times faster than SCL; sda_oe_o pulls SDA low.
module disp_xmtr_i2c_stub
    import disp_stub_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h39,
    parameter logic [BYTE_W-1:0] ID_VALUE    = 8'hB0,
    parameter logic [BYTE_W-1:0] PLUG_VALUE  = 8'h04,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    output logic link_mode_o
);

    logic              sda_s;
    logic              start_s;
    logic              stop_s;
    logic              scl_rise;
    logic              scl_fall;
    logic [BYTE_W-1:0] rd_data;
    logic              wr_open;
    logic              wr_valid;
    logic [BYTE_W-1:0] wr_byte;
    logic              rd_adv;
    logic [BYTE_W-1:0] ptr_w;
    logic              req_flag_w;
    logic              mode_w;
    tgt_state_e        state_w;

    i2c_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_o     (sda_s),
        .start_o   (start_s),
        .stop_o    (stop_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall)
    );

    i2c_tgt_engine #(
        .DEV_ADDR(DEV_ADDR)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .sda_s   (sda_s),
        .start_s (start_s),
        .stop_s  (stop_s),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .rd_data (rd_data),
        .sda_oe  (sda_oe_o),
        .wr_open (wr_open),
        .wr_valid(wr_valid),
        .wr_byte (wr_byte),
        .rd_adv  (rd_adv),
        .state_o (state_w)
    );

    disp_reg_bank #(
        .ID_VALUE  (ID_VALUE),
        .PLUG_VALUE(PLUG_VALUE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_open (wr_open),
        .wr_valid(wr_valid),
        .wr_byte (wr_byte),
        .rd_adv  (rd_adv),
        .rd_data (rd_data),
        .ptr_o   (ptr_w),
        .req_o   (req_flag_w),
        .mode_o  (mode_w)
    );

    assign link_mode_o = mode_w;

endmodule

// File: rtl/disp_stub_checker.sv
// Module: disp_stub_checker
// Protocol and state properties for disp_xmtr_i2c_stub, attached by bind.
// Assumes the synchronous active-low reset of the top module.
module disp_stub_checker
    import disp_stub_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              link_mode,
    input logic              req_flag,
    input logic              rd_adv,
    input logic              stop_s,
    input logic [BYTE_W-1:0] ptr,
    input tgt_state_e        state
);

    logic rst_seen_q;

    // Remembers that the previous edge saw reset asserted.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R11: state is cleared one edge after reset is taken.
    always @(posedge clk) begin
        if (rst_n && rst_seen_q) begin
            assert_reset_clear_R11: assert (ptr == '0 && !req_flag && !link_mode && !sda_oe)
                else $error("reset did not clear state");
        end
    end

    // R7: channel mode never stands without the request flag.
    assert_mode_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        link_mode |-> req_flag);

    // R4: each read byte advances the pointer by exactly one.
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv |=> (ptr == $past(ptr) + 8'd1));

    // R12: a STOP releases the data line.
    assert_stop_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_s |=> !sda_oe);

    // R1: an idle target never drives the data line.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

endmodule

bind disp_xmtr_i2c_stub disp_stub_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe_o),
    .link_mode(link_mode_o),
    .req_flag (req_flag_w),
    .rd_adv   (rd_adv),
    .stop_s   (stop_s),
    .ptr      (ptr_w),
    .state    (state_w)
);

// File: tb/test_disp_xmtr_i2c_stub.sv
module test_disp_xmtr_i2c_stub;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int WATCHDOG   = 190000;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    wire  sda_oe;
    wire  link_mode;
    wire  sda_line = sda_m & ~sda_oe;

    disp_xmtr_i2c_stub i_disp_xmtr_i2c_stub (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .link_mode_o(link_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  n_checks = 0;
    int  n_bad    = 0;
    int  cyc      = 0;
    bit  done     = 1'b0;

    // Vector: register, write enable, write data, expected read, expected mode.
    typedef struct packed {
        logic [7:0] reg_a;
        logic       do_wr;
        logic [7:0] wdat;
        logic [7:0] exp_rd;
        logic       exp_mode;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{8'h1A, 1'b1, 8'h04, 8'h06, 1'b0},   // R7 request only
        '{8'h1A, 1'b1, 8'h06, 8'h06, 1'b1},   // R7 request+grant
        '{8'h1A, 1'b1, 8'h04, 8'h06, 1'b1},   // R7 mode kept
        '{8'h1A, 1'b1, 8'h00, 8'h00, 1'b0},   // R8 clear
        '{8'h1B, 1'b0, 8'h00, 8'hB0, 1'b0},   // R5
        '{8'h3D, 1'b0, 8'h00, 8'h04, 1'b0},   // R6
        '{8'h1B, 1'b1, 8'h55, 8'hB0, 1'b0},   // R10 identifier ignores write
        '{8'h10, 1'b1, 8'hFF, 8'h00, 1'b0},   // R10 other register
        '{8'h1A, 1'b1, 8'h02, 8'h00, 1'b0},   // R8 grant without request
        '{8'h3D, 1'b1, 8'h00, 8'h04, 1'b0},   // R6 status ignores write
        '{8'h1A, 1'b1, 8'h06, 8'h06, 1'b1},   // R9 read while requested
        '{8'h00, 1'b0, 8'h00, 8'h00, 1'b1}    // R10 register 0
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_bit(input logic b, output logic s);
        sda_m = b;
        tick(Q);
        scl_m = 1'b1;
        tick(Q);
        s = sda_line;
        tick(Q);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        tick(Q);
        scl_m = 1'b1;
        tick(Q);
        sda_m = 1'b0;
        tick(Q);
        scl_m = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        tick(Q);
        scl_m = 1'b1;
        tick(Q);
        sda_m = 1'b1;
        tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, s);
            d = {d[6:0], s};
        end
        bus_bit(!mack, s);
    endtask

    // Full register write: address, pointer, data, each acknowledged.
    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        logic ack;
        bus_start();
        send_byte(8'h72, ack); chk("R1 address ack", {7'd0, ack}, 8'd1);
        send_byte(a, ack);     chk("R10 pointer ack", {7'd0, ack}, 8'd1);
        send_byte(d, ack);     chk("R10 data ack", {7'd0, ack}, 8'd1);
        bus_stop();
    endtask

    // Pointer write, repeated START, single byte read closed by NACK.
    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        logic ack;
        bus_start();
        send_byte(8'h72, ack);
        send_byte(a, ack);
        bus_start();
        send_byte(8'h73, ack); chk("R12 read address ack after repeated start", {7'd0, ack}, 8'd1);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        logic       ack;

        // R11: reset state at the ports.
        tick(4);
        rst_n = 1'b1;
        tick(4);
        chk("R11 sda released after reset", {7'd0, sda_oe}, 8'd0);
        chk("R11 mode clear after reset", {7'd0, link_mode}, 8'd0);

        // R1: wrong address is not acknowledged and drives nothing.
        bus_start();
        send_byte(8'h70, ack);
        chk("R1 wrong address nack", {7'd0, ack}, 8'd0);
        bus_stop();
        chk("R1 line released", {7'd0, sda_oe}, 8'd0);

        // R5 R6 R7 R8 R9 R10: vector table walk.
        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v].do_wr) reg_write(VECS[v].reg_a, VECS[v].wdat);
            reg_read(VECS[v].reg_a, d);
            chk($sformatf("R5-R10 table vector %0d read", v), d, VECS[v].exp_rd);
            chk($sformatf("R7/R8 table vector %0d mode", v), {7'd0, link_mode}, {7'd0, VECS[v].exp_mode});
        end

        // R2: a lone pointer byte writes nothing (mode is 1 here).
        reg_write(8'h00, 8'h00);          // leaves pointer at 0x01
        reg_write(8'h1A, 8'h06);          // mode 1, pointer 0x1B
        bus_start();
        send_byte(8'h72, ack);
        send_byte(8'h1A, ack);
        bus_stop();
        bus_start();
        send_byte(8'h72, ack);
        send_byte(8'h1B, ack);
        bus_stop();
        chk("R2 pointer byte did not write 0x1A", {7'd0, link_mode}, 8'd1);
        bus_start();
        send_byte(8'h73, ack);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R2 pointer loaded with 0x1B", d, 8'hB0);

        // R3: two data bytes land in 0x19 then 0x1A; pointer ends at 0x1B.
        bus_start();
        send_byte(8'h72, ack);
        send_byte(8'h19, ack);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        chk("R3 second data ack", {7'd0, ack}, 8'd1);
        bus_stop();
        chk("R3 second byte reached 0x1A", {7'd0, link_mode}, 8'd0);
        bus_start();
        send_byte(8'h73, ack);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R3 pointer advanced to 0x1B", d, 8'hB0);

        // R4 R13: burst read with increments, MSB-first identifier.
        reg_write(8'h1A, 8'h06);
        bus_start();
        send_byte(8'h72, ack);
        send_byte(8'h1A, ack);
        bus_start();
        send_byte(8'h73, ack);
        recv_byte(1'b1, d); chk("R4 burst byte 0", d, 8'h06);
        recv_byte(1'b1, d); chk("R4 R13 burst byte 1 msb first", d, 8'hB0);
        recv_byte(1'b0, d); chk("R4 burst byte 2", d, 8'h00);
        tick(3*Q);
        chk("R13 released after nack", {7'd0, sda_oe}, 8'd0);
        bus_stop();

        // R4: pointer wraps from 0xFF to 0x00 over 257 reads from 0x1B.
        bus_start();
        send_byte(8'h72, ack);
        send_byte(8'h1B, ack);
        bus_start();
        send_byte(8'h73, ack);
        for (int k = 0; k < 257; k++) begin
            recv_byte(k != 256, d);
            if (k == 0)   chk("R4 wrap first byte", d, 8'hB0);
            if (k == 34)  chk("R6 status during burst", d, 8'h04);
            if (k == 255) chk("R9 control during burst", d, 8'h06);
            if (k == 256) chk("R4 wrap back to identifier", d, 8'hB0);
        end
        bus_stop();

        // R12: wrong address, then repeated START to the right one.
        bus_start();
        send_byte(8'h74, ack);
        chk("R12 first address nack", {7'd0, ack}, 8'd0);
        bus_start();
        send_byte(8'h72, ack);
        chk("R12 repeated start rematches", {7'd0, ack}, 8'd1);
        send_byte(8'h3D, ack);
        bus_start();
        send_byte(8'h73, ack);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R12 read after repeated start", d, 8'h04);
        chk("R12 released after stop", {7'd0, sda_oe}, 8'd0);

        // R11: reset taken while channel mode is active.
        chk("R11 mode set before reset", {7'd0, link_mode}, 8'd1);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(3);
        chk("R11 mode cleared by reset", {7'd0, link_mode}, 8'd0);
        reg_read(8'h1A, d);
        chk("R11 request cleared by reset", d, 8'h00);

        finish_run();
    end

endmodule